// File: doc/BRIEF.md
# Coprocessor Register Debug Scan Chain

This block is the debug scan path that lets an external JTAG debugger reach the system-control coprocessor registers of a halted core. The debugger first picks the chain by loading the chain-select instruction and shifting in the chain number 15. It then loads the internal-test instruction and shifts a 48-bit request. The request carries a write value, a start flag, a packed register address and a direction flag. On Update-DR the block hands the request to the core clock domain. A model register file there carries it out after a configurable delay.

The access completes across scans. The debugger keeps rescanning with a no-operation request. Each Capture-DR loads the completion flag, and for reads the register value, into the chain, so the debugger learns the result on a later scan than the one that started the access. Requests cross to the core clock with a toggle and two-flop synchronizer, and completions cross back the same way.

The TCK side is built around a four-state tracker: NONE (nothing reported), BUSY (access in flight), DONE (completion reportable) and ORPHAN (in flight but abandoned by Test-Logic-Reset). Its transitions are:
- launch: NONE or DONE goes to BUSY.
- finish: BUSY goes to DONE once the acknowledge catches up.
- abandon: BUSY goes to ORPHAN on `tap_reset`.
- drain: ORPHAN goes to NONE once the acknowledge catches up.
- clear: `tap_reset` sends NONE and DONE to NONE.

The core side runs IDLE, WAIT and COMMIT. Its transitions are:
- accept: IDLE goes to WAIT when a new request toggle is seen.
- expire: WAIT goes to COMMIT when the delay counter reaches 1.
- retire: COMMIT goes to IDLE, performing the access and toggling the acknowledge.

Top module: `cpscan_chain`

## Requirements
- R1: The access chain is active only while `ir` holds the internal-test code (4'hC) and the chain number last loaded through the chain-select code (4'h2, 5-bit register, LSB shifted first) is 15. Otherwise an Update-DR starts nothing.
- R2: The 48-bit data register shifts LSB first from `tdi` and out of `tdo`. Bits 31:0 hold data, bit 32 the start/completion flag, bits 46:33 the register address and bit 47 the direction.
- R3: The address packs opcode_1 in bits 13:11, opcode_2 in bits 10:8, CRn in bits 7:4 and CRm in bits 3:0. Registers that differ only in opcode_2 are distinct.
- R4: Direction 1 writes bits 31:0 to the addressed register. Direction 0 reads it, and the value appears in bits 31:0 of the scan that first captures the completion flag as 1.
- R5: A scan with bit 32 at 0 is a poll and changes no register.
- R6: The captured bit 32 is 0 while a started access is still in flight, and 1 once it has completed.
- R7: A start request made while an access is in flight is ignored. The in-flight access is the one carried out.
- R8: An address outside the implemented set reads as zero and ignores writes, yet still completes with bit 32 captured as 1.
- R9: The register at opcode_1=0, opcode_2=0, CRn=1, CRm=0 drives `mmu_en` from bit 0, `dcache_en` from bit 2 and `icache_en` from bit 12.
- R10: `tap_reset` clears the reportable completion and the chain selection. An access abandoned while in flight is never reported as complete.
- R11: A started access is committed exactly `ACCESS_LAT` core clocks after the core side accepts it.
- R12: After reset all registers read zero and the three enable outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test-logic power-on reset, active low |
| tap_reset | input | 1 | TAP controller is in Test-Logic-Reset (synchronous to tck) |
| ir | input | IR_W | Current instruction register value |
| capture_dr | input | 1 | Capture-DR state |
| shift_dr | input | 1 | Shift-DR state |
| update_dr | input | 1 | Update-DR state |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| core_clk | input | 1 | Core clock |
| core_rst_n | input | 1 | Core-domain reset, active low |
| mmu_en | output | 1 | Control register bit 0 |
| dcache_en | output | 1 | Control register bit 2 |
| icache_en | output | 1 | Control register bit 12 |

## Verification
The bench builds the block with `ACCESS_LAT` set to 200 core clocks. The core clock runs at twice the test clock, so an access lasts about 100 test clocks, which is longer than one full 48-bit scan of about 51 test clocks. That makes two things reachable with ordinary back-to-back scans: a poll that captures the flag still at 0, and a second start request that lands while the first access is in flight. It also lets Test-Logic-Reset strike mid-access, so the abandoned-completion path is exercised. The default four-clock delay would finish every access before the next scan's capture.

// File: rtl/cpscan_pkg.sv
package cpscan_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 14;
    localparam int DR_W   = DATA_W + 1 + ADDR_W + 1;
    localparam int NREG   = 6;
    localparam int IDX_W  = $clog2(NREG);

    localparam int CTRL_IDX    = 0;
    localparam int MMU_BIT     = 0;
    localparam int DCACHE_BIT  = 2;
    localparam int ICACHE_BIT  = 12;

    typedef struct packed {
        logic              rw;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } cp_req_t;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_BUSY,
        ACC_DONE,
        ACC_ORPHAN
    } acc_state_t;

    typedef enum logic [1:0] {
        CORE_IDLE,
        CORE_WAIT,
        CORE_COMMIT
    } core_state_t;

    function automatic logic [ADDR_W-1:0] pack_addr(
        input logic [2:0] op1,
        input logic [2:0] op2,
        input logic [3:0] crn,
        input logic [3:0] crm
    );
        return {op1, op2, crn, crm};
    endfunction

    function automatic logic [ADDR_W-1:0] reg_addr(input int i);
        case (i)
            0:       return pack_addr(3'd0, 3'd0, 4'd1,  4'd0);
            1:       return pack_addr(3'd0, 3'd0, 4'd2,  4'd0);
            2:       return pack_addr(3'd0, 3'd0, 4'd5,  4'd0);
            3:       return pack_addr(3'd0, 3'd1, 4'd5,  4'd0);
            4:       return pack_addr(3'd0, 3'd0, 4'd6,  4'd0);
            default: return pack_addr(3'd7, 3'd0, 4'd15, 4'd0);
        endcase
    endfunction

endpackage

// File: rtl/cpscan_sync.sv
module cpscan_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/cpscan_decode.sv
module cpscan_decode
    import cpscan_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [IDX_W-1:0]  idx
);
    logic [NREG-1:0] match;

    for (genvar g = 0; g < NREG; g++) begin : g_match
        assign match[g] = (addr == reg_addr(g));
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < NREG; i++) begin
            if (match[i]) idx = IDX_W'(i);
        end
    end

    assign hit = |match;

    always_comb begin
        a_r3_decode_unique: assert ($onehot0(match));
    end
endmodule

// File: rtl/cpscan_tap_side.sv
module cpscan_tap_side
    import cpscan_pkg::*;
#(
    parameter int              IR_W       = 4,
    parameter logic [IR_W-1:0] IR_SELECT  = 4'h2,
    parameter logic [IR_W-1:0] IR_ACCESS  = 4'hC,
    parameter int              SEL_W      = 5,
    parameter int              CHAIN_ID   = 15
) (
    input  logic              tck,
    input  logic              trst_n,
    input  logic              tap_reset,
    input  logic [IR_W-1:0]   ir,
    input  logic              capture_dr,
    input  logic              shift_dr,
    input  logic              update_dr,
    input  logic              tdi,
    output logic              tdo,
    input  logic              ack_s,
    input  logic [DATA_W-1:0] rd_data,
    output cp_req_t           req,
    output logic              req_tgl
);
    localparam int FLAG_BIT = DATA_W;
    localparam int ADDR_LO  = DATA_W + 1;
    localparam int RW_BIT   = DR_W - 1;

    acc_state_t       st, st_nx;
    logic [SEL_W-1:0] chain_sel, sel_sr;
    logic [DR_W-1:0]  sr;
    logic             sel_ir, chain_act, in_flight, launch, cap_done;

    assign sel_ir    = (ir == IR_SELECT);
    assign chain_act = (ir == IR_ACCESS) && (chain_sel == SEL_W'(CHAIN_ID));
    assign in_flight = (req_tgl != ack_s);

    // state register
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) st <= ACC_NONE;
        else         st <= st_nx;
    end

    // next state and outputs of the tracker
    always_comb begin
        launch   = 1'b0;
        cap_done = 1'b0;
        st_nx    = st;
        unique case (st)
            ACC_NONE: begin
                launch = chain_act && update_dr && sr[FLAG_BIT];
                if (launch) st_nx = ACC_BUSY;
            end
            ACC_BUSY: begin
                if (!in_flight) st_nx = ACC_DONE;
            end
            ACC_DONE: begin
                cap_done = 1'b1;
                launch   = chain_act && update_dr && sr[FLAG_BIT];
                if (launch) st_nx = ACC_BUSY;
            end
            ACC_ORPHAN: begin
                if (!in_flight) st_nx = ACC_NONE;
            end
        endcase
        if (tap_reset) begin
            launch = 1'b0;
            st_nx  = in_flight ? ACC_ORPHAN : ACC_NONE;
        end
    end

    // chain select register
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            chain_sel <= '0;
            sel_sr    <= '0;
        end else if (tap_reset) begin
            chain_sel <= '0;
            sel_sr    <= '0;
        end else if (sel_ir) begin
            if (capture_dr)     sel_sr    <= chain_sel;
            else if (shift_dr)  sel_sr    <= {tdi, sel_sr[SEL_W-1:1]};
            else if (update_dr) chain_sel <= sel_sr;
        end
    end

    // access data register
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            sr <= '0;
        end else if (tap_reset) begin
            sr <= '0;
        end else if (chain_act) begin
            if (capture_dr)    sr <= {1'b0, {ADDR_W{1'b0}}, cap_done, rd_data};
            else if (shift_dr) sr <= {tdi, sr[DR_W-1:1]};
        end
    end

    // request holding registers, stable while in flight
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            req     <= '0;
            req_tgl <= 1'b0;
        end else if (launch) begin
            req.rw   <= sr[RW_BIT];
            req.addr <= sr[RW_BIT-1:ADDR_LO];
            req.data <= sr[DATA_W-1:0];
            req_tgl  <= ~req_tgl;
        end
    end

    always_comb begin
        if (sel_ir)         tdo = sel_sr[0];
        else if (chain_act) tdo = sr[0];
        else                tdo = 1'b0;
    end

    a_r1_launch_needs_chain: assert property (@(posedge tck) disable iff (!trst_n)
        !$stable(req_tgl) |-> ($past(ir) == IR_ACCESS && $past(chain_sel) == SEL_W'(CHAIN_ID)));

    a_r7_no_relaunch: assert property (@(posedge tck) disable iff (!trst_n)
        in_flight |=> $stable(req_tgl));

    a_r6_done_settled: assert property (@(posedge tck) disable iff (!trst_n)
        (st == ACC_DONE) |-> !in_flight);

    a_r10_reset_clears: assert property (@(posedge tck) disable iff (!trst_n)
        tap_reset |=> (st != ACC_DONE && chain_sel == '0));
endmodule

// File: rtl/cpscan_core_side.sv
module cpscan_core_side
    import cpscan_pkg::*;
#(
    parameter int ACCESS_LAT = 4
) (
    input  logic              core_clk,
    input  logic              core_rst_n,
    input  logic              req_s,
    input  cp_req_t           req,
    output logic              ack_tgl,
    output logic [DATA_W-1:0] rd_data,
    output logic              mmu_en,
    output logic              dcache_en,
    output logic              icache_en
);
    localparam int CNT_W = $clog2(ACCESS_LAT + 2);

    core_state_t                  st, st_nx;
    logic [CNT_W-1:0]             cnt;
    logic [NREG-1:0][DATA_W-1:0]  regs;
    logic                         hit, accept, commit;
    logic [IDX_W-1:0]             idx;

    cpscan_decode u_dec (
        .addr (req.addr),
        .hit  (hit),
        .idx  (idx)
    );

    // state register
    always_ff @(posedge core_clk or negedge core_rst_n) begin
        if (!core_rst_n) st <= CORE_IDLE;
        else             st <= st_nx;
    end

    // next state and strobes
    always_comb begin
        st_nx  = st;
        accept = 1'b0;
        commit = 1'b0;
        unique case (st)
            CORE_IDLE: begin
                accept = (req_s != ack_tgl);
                if (accept) st_nx = CORE_WAIT;
            end
            CORE_WAIT: begin
                if (cnt == CNT_W'(1)) st_nx = CORE_COMMIT;
            end
            CORE_COMMIT: begin
                commit = 1'b1;
                st_nx  = CORE_IDLE;
            end
            default: st_nx = CORE_IDLE;
        endcase
    end

    always_ff @(posedge core_clk or negedge core_rst_n) begin
        if (!core_rst_n)         cnt <= '0;
        else if (accept)         cnt <= CNT_W'(ACCESS_LAT - 1);
        else if (st == CORE_WAIT) cnt <= cnt - 1'b1;
    end

    always_ff @(posedge core_clk or negedge core_rst_n) begin
        if (!core_rst_n) begin
            regs    <= '0;
            rd_data <= '0;
            ack_tgl <= 1'b0;
        end else if (commit) begin
            ack_tgl <= ~ack_tgl;
            if (req.rw) begin
                for (int i = 0; i < NREG; i++) begin
                    if (hit && idx == IDX_W'(i)) regs[i] <= req.data;
                end
            end else begin
                rd_data <= hit ? regs[idx] : '0;
            end
        end
    end

    assign mmu_en    = regs[CTRL_IDX][MMU_BIT];
    assign dcache_en = regs[CTRL_IDX][DCACHE_BIT];
    assign icache_en = regs[CTRL_IDX][ICACHE_BIT];

    // latency watch counter for R11
    logic [CNT_W:0] lat_seen;
    always_ff @(posedge core_clk or negedge core_rst_n) begin
        if (!core_rst_n)          lat_seen <= '0;
        else if (accept)          lat_seen <= '0;
        else if (st != CORE_IDLE) lat_seen <= lat_seen + 1'b1;
    end

    initial begin
        a_r11_lat_min: assert (ACCESS_LAT >= 2);
    end

    a_r11_latency: assert property (@(posedge core_clk) disable iff (!core_rst_n)
        !$stable(ack_tgl) |-> (lat_seen == (CNT_W+1)'(ACCESS_LAT)));

    a_r8_unmapped_write: assert property (@(posedge core_clk) disable iff (!core_rst_n)
        (commit && req.rw && !hit) |=> $stable(regs));

    a_r4_read_value: assert property (@(posedge core_clk) disable iff (!core_rst_n)
        (commit && !req.rw && hit) |=> (rd_data == $past(regs[idx])));

    a_r8_unmapped_read: assert property (@(posedge core_clk) disable iff (!core_rst_n)
        (commit && !req.rw && !hit) |=> (rd_data == '0));
endmodule

// File: rtl/cpscan_chain.sv
module cpscan_chain
    import cpscan_pkg::*;
#(
    parameter int              IR_W       = 4,
    parameter logic [IR_W-1:0] IR_SELECT  = 4'h2,
    parameter logic [IR_W-1:0] IR_ACCESS  = 4'hC,
    parameter int              SEL_W      = 5,
    parameter int              CHAIN_ID   = 15,
    parameter int              ACCESS_LAT = 4
) (
    input  logic            tck,
    input  logic            trst_n,
    input  logic            tap_reset,
    input  logic [IR_W-1:0] ir,
    input  logic            capture_dr,
    input  logic            shift_dr,
    input  logic            update_dr,
    input  logic            tdi,
    output logic            tdo,
    input  logic            core_clk,
    input  logic            core_rst_n,
    output logic            mmu_en,
    output logic            dcache_en,
    output logic            icache_en
);
    cp_req_t           req;
    logic              req_tgl, req_s, ack_tgl, ack_s;
    logic [DATA_W-1:0] rd_data;

    cpscan_tap_side #(
        .IR_W      (IR_W),
        .IR_SELECT (IR_SELECT),
        .IR_ACCESS (IR_ACCESS),
        .SEL_W     (SEL_W),
        .CHAIN_ID  (CHAIN_ID)
    ) u_tap (
        .tck        (tck),
        .trst_n     (trst_n),
        .tap_reset  (tap_reset),
        .ir         (ir),
        .capture_dr (capture_dr),
        .shift_dr   (shift_dr),
        .update_dr  (update_dr),
        .tdi        (tdi),
        .tdo        (tdo),
        .ack_s      (ack_s),
        .rd_data    (rd_data),
        .req        (req),
        .req_tgl    (req_tgl)
    );

    cpscan_sync #(.W(1)) u_req_sync (
        .clk   (core_clk),
        .rst_n (core_rst_n),
        .d     (req_tgl),
        .q     (req_s)
    );

    cpscan_sync #(.W(1)) u_ack_sync (
        .clk   (tck),
        .rst_n (trst_n),
        .d     (ack_tgl),
        .q     (ack_s)
    );

    cpscan_core_side #(
        .ACCESS_LAT (ACCESS_LAT)
    ) u_core (
        .core_clk   (core_clk),
        .core_rst_n (core_rst_n),
        .req_s      (req_s),
        .req        (req),
        .ack_tgl    (ack_tgl),
        .rd_data    (rd_data),
        .mmu_en     (mmu_en),
        .dcache_en  (dcache_en),
        .icache_en  (icache_en)
    );
endmodule

// File: tb/sim_cpscan_chain.sv
module sim_cpscan_chain;
    localparam int TCK_PERIOD  = 20;
    localparam int CORE_PERIOD = 10;
    localparam int LAT         = 200;
    localparam logic [3:0] IR_SEL = 4'h2;
    localparam logic [3:0] IR_ACC = 4'hC;

    logic       tck = 1'b0, core_clk = 1'b0;
    logic       trst_n = 1'b0, core_rst_n = 1'b0, tap_reset = 1'b0;
    logic [3:0] ir = 4'hF;
    logic       capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0, tdi = 1'b0;
    logic       tdo, mmu_en, dcache_en, icache_en;

    int n_checks = 0;
    int n_fail   = 0;

    always #(TCK_PERIOD/2)  tck = ~tck;
    always #(CORE_PERIOD/2) core_clk = ~core_clk;

    cpscan_chain #(.ACCESS_LAT(LAT)) u0 (
        .tck(tck), .trst_n(trst_n), .tap_reset(tap_reset), .ir(ir),
        .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
        .tdi(tdi), .tdo(tdo), .core_clk(core_clk), .core_rst_n(core_rst_n),
        .mmu_en(mmu_en), .dcache_en(dcache_en), .icache_en(icache_en)
    );

    function automatic logic [13:0] ad(input int o1, input int o2, input int n, input int m);
        return {3'(o1), 3'(o2), 4'(n), 4'(m)};
    endfunction

    localparam logic [13:0] A_CTRL = 14'h0010;
    localparam logic [13:0] A_TTB  = 14'h0020;
    localparam logic [13:0] A_DFSR = 14'h0050;
    localparam logic [13:0] A_IFSR = 14'h0150;
    localparam logic [13:0] A_FAR  = 14'h0060;
    localparam logic [13:0] A_CDBG = 14'h38F0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic scan(input int n, input logic [47:0] din, output logic [47:0] dout);
        dout = '0;
        @(negedge tck); capture_dr = 1'b1;
        @(posedge tck);
        @(negedge tck); capture_dr = 1'b0; shift_dr = 1'b1;
        for (int i = 0; i < n; i++) begin
            tdi     = din[i];
            dout[i] = tdo;
            @(posedge tck);
            @(negedge tck);
        end
        shift_dr = 1'b0; update_dr = 1'b1;
        @(posedge tck);
        @(negedge tck); update_dr = 1'b0;
    endtask

    task automatic select_chain(input logic [4:0] c);
        logic [47:0] d;
        @(negedge tck); ir = IR_SEL;
        scan(5, {43'b0, c}, d);
        ir = IR_ACC;
    endtask

    task automatic launch(input logic rw, input logic [13:0] a, input logic [31:0] v);
        logic [47:0] d;
        scan(48, {rw, a, 1'b1, v}, d);
    endtask

    task automatic poll(output logic done, output logic [31:0] v);
        logic [47:0] d;
        scan(48, 48'h0, d);
        done = d[32];
        v    = d[31:0];
    endtask

    task automatic access(input logic rw, input logic [13:0] a, input logic [31:0] v,
                          output logic [31:0] rv, output logic ok);
        logic done;
        launch(rw, a, v);
        ok = 1'b0; rv = '0;
        for (int k = 0; k < 10 && !ok; k++) begin
            poll(done, rv);
            ok = done;
        end
    endtask

    task automatic t_reset;
        logic [31:0] rv; logic ok;
        check("R12 mmu_en", 32'(mmu_en), 0);
        check("R12 dcache_en", 32'(dcache_en), 0);
        check("R12 icache_en", 32'(icache_en), 0);
        select_chain(5'd15);
        access(1'b0, A_CTRL, 0, rv, ok);
        check("R12 ctrl read", rv, 0);
        check("R6 completes", 32'(ok), 1);
    endtask

    task automatic t_ctrl;
        logic [31:0] rv; logic ok;
        access(1'b1, A_CTRL, 32'h0000_1005, rv, ok);
        check("R9 mmu", 32'(mmu_en), 1);
        check("R9 dcache", 32'(dcache_en), 1);
        check("R9 icache", 32'(icache_en), 1);
        access(1'b1, A_CTRL, 32'h0000_0004, rv, ok);
        check("R9 mmu off", 32'(mmu_en), 0);
        check("R9 dcache on", 32'(dcache_en), 1);
        check("R9 icache off", 32'(icache_en), 0);
        access(1'b0, A_CTRL, 0, rv, ok);
        check("R4 ctrl readback", rv, 32'h0000_0004);
    endtask

    task automatic t_fields;
        logic [31:0] rv; logic ok;
        access(1'b1, ad(0,0,5,0), 32'hA5A5_0001, rv, ok);
        access(1'b1, ad(0,1,5,0), 32'h5A5A_0002, rv, ok);
        access(1'b0, A_DFSR, 0, rv, ok);
        check("R3 dfsr", rv, 32'hA5A5_0001);
        access(1'b0, A_IFSR, 0, rv, ok);
        check("R3 ifsr op2", rv, 32'h5A5A_0002);
        access(1'b1, ad(7,0,15,0), 32'h8000_0001, rv, ok);
        access(1'b0, A_CDBG, 0, rv, ok);
        check("R2 bit order cdbg", rv, 32'h8000_0001);
    endtask

    task automatic t_nop;
        logic [31:0] rv; logic ok, done;
        logic [47:0] d;
        access(1'b1, A_FAR, 32'h1234_5678, rv, ok);
        scan(48, {1'b0, A_FAR, 1'b0, 32'hDEAD_BEEF}, d);
        scan(48, {1'b1, A_FAR, 1'b0, 32'hFFFF_FFFF}, d);
        poll(done, rv);
        access(1'b0, A_FAR, 0, rv, ok);
        check("R5 poll no effect", rv, 32'h1234_5678);
    endtask

    task automatic t_pending;
        logic [31:0] rv; logic ok, done;
        launch(1'b1, A_TTB, 32'h0000_4000);
        poll(done, rv);
        check("R6 flag low in flight", 32'(done), 0);
        launch(1'b1, A_TTB, 32'h0000_8000);
        ok = 1'b0;
        for (int k = 0; k < 10 && !ok; k++) begin
            poll(done, rv);
            ok = done;
        end
        check("R6 flag high after", 32'(ok), 1);
        access(1'b0, A_TTB, 0, rv, ok);
        check("R7 relaunch ignored", rv, 32'h0000_4000);
    endtask

    task automatic t_unmapped;
        logic [31:0] rv; logic ok;
        access(1'b1, ad(2,3,9,9), 32'hFFFF_FFFF, rv, ok);
        check("R8 write completes", 32'(ok), 1);
        access(1'b0, ad(2,3,9,9), 0, rv, ok);
        check("R8 reads zero", rv, 0);
        check("R8 read completes", 32'(ok), 1);
        access(1'b0, A_CTRL, 0, rv, ok);
        check("R8 ctrl intact", rv, 32'h0000_0004);
    endtask

    task automatic t_select;
        logic [31:0] rv; logic ok;
        logic [47:0] d;
        select_chain(5'd14);
        launch(1'b1, A_CDBG, 32'h0BAD_0BAD);
        repeat (300) @(negedge tck);
        select_chain(5'd15);
        @(negedge tck); ir = 4'h4;
        scan(48, {1'b1, A_CDBG, 1'b1, 32'h0BAD_0BAD}, d);
        repeat (300) @(negedge tck);
        ir = IR_ACC;
        access(1'b0, A_CDBG, 0, rv, ok);
        check("R1 unselected ignored", rv, 32'h8000_0001);
    endtask

    task automatic t_tlr;
        logic [31:0] rv; logic ok, done;
        launch(1'b1, A_FAR, 32'h0000_0077);
        @(negedge tck); tap_reset = 1'b1;
        @(negedge tck); tap_reset = 1'b0;
        select_chain(5'd15);
        poll(done, rv);
        check("R10 flag cleared", 32'(done), 0);
        repeat (300) @(negedge tck);
        poll(done, rv);
        check("R10 orphan unreported", 32'(done), 0);
        access(1'b0, A_DFSR, 0, rv, ok);
        check("R10 usable after", rv, 32'hA5A5_0001);
    endtask

    initial begin
        #(TCK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge tck);
        trst_n = 1'b1; core_rst_n = 1'b1;
        repeat (2) @(negedge tck);
        t_reset();
        t_ctrl();
        t_fields();
        t_nop();
        t_pending();
        t_unmapped();
        t_select();
        t_tlr();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule